// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking

The block samples SDRAM control pins on each rising clock edge: chip select, row strobe, column strobe and write enable, all active low, plus a 12-bit address. The top address bit picks one of two banks. The block decodes the command and presents it, together with its bank, row or column field and auto-precharge request, on registered outputs one cycle later.

For each bank, the block tracks whether a row is open. It also counts the cycles since the bank's activate, and it follows any pending auto-precharge. Column commands issued too early or to a closed bank, and activates to a bank that is already open, raise a violation flag. A violating command leaves the bank state untouched. The activate-to-column delay, CAS latency and burst length come in as static configuration inputs.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: Outputs are registered; each cycle's pins appear decoded after the next rising edge. cmd_o encodings: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 other. Chip select high, or chip select low with all three strobes high, gives 0. With chip select low and the pins {row, column, write} = 011 the command is 1; 101 gives 2, 100 gives 3 and 010 gives 4. Any other pattern gives 5.
- R2: bank_o is address bit 11 for commands 1 to 4 and 0 otherwise. For command 1, row_col_o carries address bits 10:0. For commands 2 and 3 it carries bits 7:0, zero-extended, and is 0 otherwise. ap_o equals address bit 10 on commands 2 and 3 and is 0 otherwise.
- R3: While reset is low, every output is 0 and both banks are closed.
- R4: A read or write to a closed bank sets viol_o for that output cycle and changes no bank state.
- R5: A read or write issued exactly trcd_i edges after the activate of its bank (trcd_i from 1 to 7) is legal. One issued earlier sets viol_o.
- R6: An activate to a bank that has an open row sets viol_o and keeps the existing row and its timing.
- R7: A precharge closes the addressed bank. With address bit 10 set, it closes both banks. A precharge to a closed bank is not a violation.
- R8: An accepted write with auto-precharge closes its bank, so that a command issued BL edges later sees it closed. BL is 1, 2, 4 or 8 for bl_i 0 to 3. A read or write to that bank in the meantime is a violation, and so is an activate.
- R9: An accepted read with auto-precharge closes its bank BL+CL edges after the read. CL is 2 for cl_i=0 and 3 for cl_i=1.
- R10: A precharge issued while an auto-precharge is pending cancels the pending close, so a row opened afterwards stays open.
- R11: No-op and other commands never set viol_o and leave both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Bit 11 bank, bits 10:0 row or column/auto-precharge |
| trcd_i | input | 3 | Activate-to-column delay in cycles |
| cl_i | input | 1 | CAS latency select, 0 = 2, 1 = 3 |
| bl_i | input | 2 | Burst length code, BL = 1 << bl_i |
| cmd_o | output | 3 | Decoded command |
| bank_o | output | 1 | Decoded bank |
| row_col_o | output | 11 | Row or column field |
| ap_o | output | 1 | Auto-precharge request |
| viol_o | output | 1 | Illegal access flag |

## Verification
Two functions can act on a bank in the same cycle: the close driven by an auto-precharge countdown, and a newly decoded command that targets the same bank. The bench issues an activate one edge before the computed close, where it must be flagged, and again exactly on the close edge, where it must be accepted. It does this for a write with auto-precharge and again for a read with auto-precharge. It also sends a precharge while a long close countdown is running, reopens the bank, and then reads after the old countdown would have expired. That read proves the cancelled timer did not close the new row.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_OTHER = 3'd5
  } cmd_e;
endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
  import sdram_dec_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = CMD_NOP;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        default: cmd_o = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int TRCD_W = 3,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              col_i,
  input  logic              ap_i,
  input  logic [LEN_W-1:0]  close_len_i,
  input  logic              pre_i,
  input  logic [TRCD_W-1:0] trcd_i,
  output logic              open_o,
  output logic              ready_o
);
  localparam logic [TRCD_W-1:0] CNT_MAX = '1;

  logic              open_q, closing_q;
  logic [TRCD_W-1:0] cnt_q;
  logic [LEN_W-1:0]  ap_cnt_q;

  assign open_o  = open_q;
  assign ready_o = open_q && !closing_q && (cnt_q >= trcd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      closing_q <= 1'b0;
      cnt_q     <= '0;
      ap_cnt_q  <= '0;
    end else if (pre_i) begin
      open_q    <= 1'b0;
      closing_q <= 1'b0;
    end else if (act_i) begin
      open_q    <= 1'b1;
      closing_q <= 1'b0;
      cnt_q     <= TRCD_W'(1);
    end else begin
      if (open_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (col_i && ap_i) begin
        // close so that a command close_len edges later sees the bank closed
        if (close_len_i == LEN_W'(1)) open_q <= 1'b0;
        else begin
          closing_q <= 1'b1;
          ap_cnt_q  <= close_len_i - 1'b1;
        end
      end else if (closing_q) begin
        if (ap_cnt_q == LEN_W'(1)) begin
          open_q    <= 1'b0;
          closing_q <= 1'b0;
        end else ap_cnt_q <= ap_cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 10,
  parameter int TRCD_W    = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cs_ni,
  input  logic                         ras_ni,
  input  logic                         cas_ni,
  input  logic                         we_ni,
  input  logic [ROW_W+$clog2(NUM_BANKS)-1:0] addr_i,
  input  logic [TRCD_W-1:0]            trcd_i,
  input  logic                         cl_i,
  input  logic [1:0]                   bl_i,
  output logic [2:0]                   cmd_o,
  output logic [$clog2(NUM_BANKS)-1:0] bank_o,
  output logic [ROW_W-1:0]             row_col_o,
  output logic                         ap_o,
  output logic                         viol_o
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ADDR_W = ROW_W + BANK_W;
  localparam int LEN_W  = 4;

  cmd_e              cmd;
  logic [BANK_W-1:0] bank_sel;
  logic              is_col, ap_req, viol_d;
  logic [LEN_W-1:0]  close_len;
  logic [NUM_BANKS-1:0] open_w, ready_w;
  logic [ROW_W-1:0]  row_col_d;

  sdram_pin_decode u_dec (
    .cs_ni (cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o(cmd)
  );

  assign bank_sel  = addr_i[ADDR_W-1 -: BANK_W];
  assign is_col    = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign ap_req    = addr_i[AP_BIT];
  assign close_len = (LEN_W'(1) << bl_i)
                   + ((cmd == CMD_RD) ? (cl_i ? LEN_W'(3) : LEN_W'(2)) : LEN_W'(0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == BANK_W'(b));
    sdram_bank_state #(.TRCD_W(TRCD_W), .LEN_W(LEN_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (cmd == CMD_ACT && hit && !open_w[b]),
      .col_i      (is_col && hit && ready_w[b]),
      .ap_i       (ap_req),
      .close_len_i(close_len),
      .pre_i      (cmd == CMD_PRE && (hit || ap_req)),
      .trcd_i     (trcd_i),
      .open_o     (open_w[b]),
      .ready_o    (ready_w[b])
    );
  end

  assign viol_d = ((cmd == CMD_ACT) && open_w[bank_sel])
               || (is_col && !ready_w[bank_sel]);

  always_comb begin
    row_col_d = '0;
    if (cmd == CMD_ACT) row_col_d = addr_i[ROW_W-1:0];
    else if (is_col)    row_col_d = ROW_W'(addr_i[COL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      bank_o    <= '0;
      row_col_o <= '0;
      ap_o      <= 1'b0;
      viol_o    <= 1'b0;
    end else begin
      cmd_o     <= cmd;
      bank_o    <= (cmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE}) ? bank_sel : '0;
      row_col_o <= row_col_d;
      ap_o      <= is_col && ap_req;
      viol_o    <= viol_d;
    end
  end
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk #(
  parameter int NUM_BANKS = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int TRCD_W    = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cs_ni,
  input logic [TRCD_W-1:0]            trcd_i,
  input logic [2:0]                   cmd_o,
  input logic [$clog2(NUM_BANKS)-1:0] bank_o,
  input logic [ROW_W-1:0]             row_col_o,
  input logic                         ap_o,
  input logic                         viol_o
);
  always @(posedge clk_i)
    if (!rst_ni)
      p_reset_quiet_r3: assert (cmd_o == 3'd0 && bank_o == '0 && row_col_o == '0 && !ap_o && !viol_o);

  p_deselect_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> cmd_o == 3'd0);

  p_col_field_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd2 || cmd_o == 3'd3) |-> (row_col_o >> COL_W) == '0);

  p_ap_col_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_o |-> (cmd_o == 3'd2 || cmd_o == 3'd3));

  p_idle_no_viol_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd0 || cmd_o == 3'd5) |-> !viol_o);

  p_double_act_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 3'd1 && $past(cmd_o) == 3'd1 && !$past(viol_o) && $past(bank_o) == bank_o)
      |-> viol_o);

  p_early_col_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == 3'd2 || cmd_o == 3'd3) && $past(cmd_o) == 3'd1 && !$past(viol_o)
      && $past(bank_o) == bank_o && trcd_i > TRCD_W'(1) && $stable(trcd_i)) |-> viol_o);
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .TRCD_W(TRCD_W)
) chk_i (.*);

// File: tb/sdram_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_decoder_tb_top;
  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_OTH = 5, C_IDLE = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [11:0] addr_i = '0;
  logic [2:0]  trcd_i = 3'd2;
  logic        cl_i = 1'b0;
  logic [1:0]  bl_i = 2'd2;
  logic [2:0]  cmd_o;
  logic        bank_o, ap_o, viol_o;
  logic [10:0] row_col_o;

  typedef struct {
    logic [2:0] cmd; logic bank; logic [10:0] rc; logic ap; logic viol;
    int stamp; string tag;
  } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  sdram_cmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni(we_ni), .addr_i(addr_i), .trcd_i(trcd_i), .cl_i(cl_i), .bl_i(bl_i),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_col_o(row_col_o), .ap_o(ap_o), .viol_o(viol_o)
  );

  task automatic issue(input int c, input logic b, input logic [10:0] a,
                       input logic ev, input string tag);
    exp_t e;
    @(negedge clk);
    cs_ni = (c == C_NOP);
    case (c)
      C_ACT:   {ras_ni, cas_ni, we_ni} = 3'b011;
      C_RD:    {ras_ni, cas_ni, we_ni} = 3'b101;
      C_WR:    {ras_ni, cas_ni, we_ni} = 3'b100;
      C_PRE:   {ras_ni, cas_ni, we_ni} = 3'b010;
      C_OTH:   {ras_ni, cas_ni, we_ni} = 3'b001;
      default: {ras_ni, cas_ni, we_ni} = 3'b111;
    endcase
    addr_i  = {b, a};
    e.cmd   = (c == C_IDLE) ? 3'd0 : 3'(c);
    e.bank  = (c >= C_ACT && c <= C_PRE) ? b : 1'b0;
    e.rc    = (c == C_ACT) ? a : (c == C_RD || c == C_WR) ? {3'b0, a[7:0]} : 11'd0;
    e.ap    = (c == C_RD || c == C_WR) ? a[10] : 1'b0;
    e.viol  = ev;
    e.stamp = cyc;
    e.tag   = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp < cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cmd_o !== e.cmd || bank_o !== e.bank || row_col_o !== e.rc
          || ap_o !== e.ap || viol_o !== e.viol) begin
        errors++;
        $display("FAIL %s: got cmd=%0d bank=%0d rc=%h ap=%0d viol=%0d, exp cmd=%0d bank=%0d rc=%h ap=%0d viol=%0d",
                 e.tag, cmd_o, bank_o, row_col_o, ap_o, viol_o,
                 e.cmd, e.bank, e.rc, e.ap, e.viol);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got hung run, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_o !== 0 || bank_o !== 0 || row_col_o !== 0 || ap_o !== 0 || viol_o !== 0) begin
      errors++;
      $display("FAIL R3: got cmd=%0d rc=%h viol=%0d, exp all zero", cmd_o, row_col_o, viol_o);
    end
    rst_ni = 1'b1;
    issue(C_NOP, 1, 11'h7FF, 0, "R1 deselect");
    issue(C_IDLE, 1, 11'h123, 0, "R1 idle strobes");
    issue(C_RD, 0, 11'h005, 1, "R4 read closed");
    issue(C_WR, 1, 11'h003, 1, "R4 write closed");
    issue(C_ACT, 0, 11'h155, 0, "R1 activate");
    issue(C_RD, 0, 11'h012, 1, "R5 early read");
    issue(C_RD, 0, 11'h0A5, 0, "R5 read at trcd");
    issue(C_ACT, 0, 11'h0AA, 1, "R6 activate open bank");
    issue(C_WR, 0, 11'h0AB, 0, "R6 state kept");
    issue(C_OTH, 0, 11'h000, 0, "R11 other command");
    issue(C_RD, 0, 11'h333, 0, "R11 bank still open, R2 column trim");
    issue(C_ACT, 1, 11'h7FF, 0, "R2 full row");
    issue(C_IDLE, 0, 11'h000, 0, "R1 idle");
    issue(C_WR, 1, 11'h4FF, 0, "R8 write auto-precharge");
    issue(C_RD, 1, 11'h001, 1, "R8 column while closing");
    issue(C_IDLE, 0, 11'h000, 0, "R8 gap");
    issue(C_ACT, 1, 11'h010, 1, "R8 activate before close");
    issue(C_ACT, 1, 11'h010, 0, "R8 activate at close edge");
    issue(C_PRE, 1, 11'h000, 0, "R7 precharge one bank");
    issue(C_RD, 1, 11'h002, 1, "R7 bank closed by precharge");
    issue(C_RD, 0, 11'h002, 0, "R7 other bank untouched");
    issue(C_PRE, 0, 11'h400, 0, "R7 precharge all");
    issue(C_RD, 0, 11'h003, 1, "R7 all closed");
    issue(C_PRE, 1, 11'h000, 0, "R7 precharge closed bank");
    @(negedge clk); cl_i = 1'b1; bl_i = 2'd0;
    issue(C_ACT, 0, 11'h123, 0, "R9 activate");
    issue(C_IDLE, 0, 11'h000, 0, "R9 gap");
    issue(C_RD, 0, 11'h407, 0, "R9 read auto-precharge");
    issue(C_IDLE, 0, 11'h000, 0, "R9 gap");
    issue(C_IDLE, 0, 11'h000, 0, "R9 gap");
    issue(C_ACT, 0, 11'h124, 1, "R9 activate before BL+CL");
    issue(C_ACT, 0, 11'h124, 0, "R9 activate at BL+CL");
    @(negedge clk); trcd_i = 3'd3; bl_i = 2'd3;
    issue(C_ACT, 1, 11'h200, 0, "R5 activate trcd3");
    issue(C_IDLE, 0, 11'h000, 0, "R5 gap");
    issue(C_RD, 1, 11'h008, 1, "R5 trcd3 early");
    issue(C_RD, 1, 11'h009, 0, "R5 trcd3 exact");
    issue(C_WR, 1, 11'h401, 0, "R10 write auto-precharge");
    issue(C_PRE, 1, 11'h000, 0, "R10 precharge cancels");
    issue(C_ACT, 1, 11'h0F0, 0, "R10 reopen");
    for (int i = 0; i < 6; i++) issue(C_IDLE, 0, 11'h000, 0, "R10 wait");
    issue(C_RD, 1, 11'h00C, 0, "R10 row survives old timer");
    issue(C_NOP, 0, 11'h000, 0, "R1 tail");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule